// File: doc/BRIEF.md
# Timer Input Capture Unit with Glitch Filter

This block records the moment an external event happens. It runs a free-running 16-bit counter. When a qualifying edge arrives on the chosen trigger line, it copies the counter into a 16-bit capture register and raises a capture flag. The trigger line is either a dedicated capture pin or the output of an off-block comparator, selected by one control bit. Both lines pass through a two-stage synchronizer. A control bit chooses whether rising or falling edges count.

An optional glitch filter sits between the synchronizer and the edge detector. The filter accepts a new level only after four consecutive samples agree on it. Enabling the filter therefore rejects short pulses and adds exactly four clock cycles of latency to every capture.

Software reaches the block over an 8-bit register bus. The counter and the capture register are both 16 bits wide, so they are read and written through one shared high-byte holding register:

- **Read:** read the low byte first; this loads the high byte into the holding register, and a later high-byte read returns it.
- **Write:** write the high byte first into the holding register; the low-byte write then commits all 16 bits at once.

The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. The bus is single-cycle: a read returns its data combinationally in the same cycle, and a write takes effect at the next clock edge.

Top module: `capture_unit`

## Requirements
- R1: Control register (address 0) bit 0 selects the trigger line: 0 picks `cap_pin`, 1 picks `cmp_in`. Activity on the line that is not selected causes no capture.
- R2: With the filter disabled, a change presented on the selected line between edges E and E+1 captures the counter value that holds just after edge E+2. That is two cycles of synchronizer latency.
- R3: Control bit 1 enables the glitch filter. When it is set:
  - a capture stores the counter value four cycles later than the unfiltered case (the value just after edge E+6);
  - a pulse on the selected line shorter than four cycles causes no capture.
- R4: Control bit 2 picks the edge: 1 captures on rising edges, 0 on falling edges. Edges of the other polarity cause no capture.
- R5: Every capture sets the capture flag, which is status register (address 1) bit 0. Writing 1 to that bit clears the flag; writing 0 leaves it unchanged. When a capture and a clear fall in the same cycle, the capture wins.
- R6: `irq` is high exactly when the capture flag, control bit 3 (interrupt enable) and the `glb_irq_en` input are all 1.
- R7: Reading the low byte of the capture register (address 2) or of the counter (address 4) loads that register's high byte into the holding register. Reading address 3 or address 5 returns the holding register. A low-byte-first read therefore yields a consistent 16-bit value even if the counter has moved on.
- R8: Writing address 3 or address 5 loads the holding register. Writing address 2 or address 4 commits {holding, data} into the capture register or the counter, respectively. One holding register serves both, so one high-byte write can feed several low-byte commits.
- R9: The counter increments by one every cycle in which it is not written, wrapping from 0xFFFF to 0x0000.
- R10: After reset, the control register, the flag, the capture register, the counter and the holding register are all 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (loads the holding register on low-byte reads) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| cap_pin | input | 1 | Dedicated capture pin, asynchronous |
| cmp_in | input | 1 | Comparator output used as the alternate trigger, asynchronous |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Capture interrupt request |

## Verification
The assertions check the following on every cycle:
- the filtered level only moves after four agreeing samples;
- edge events never come back to back while the edge select is unchanged;
- the counter steps by one unless written;
- the capture register and the flag change only after a capture or a bus access.

The bench's scenarios are needed to show what a single-cycle property cannot:
- the exact captured value, which reveals the two-cycle and six-cycle latencies;
- glitch rejection;
- the ignored trigger line;
- the atomic low-then-high read across a counter carry, and the reuse of one written high byte for two registers.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam int BUS_W = 8;
  localparam int CNT_W = 2 * BUS_W;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_CAP_LO = 3'd2,
    A_CAP_HI = 3'd3,
    A_CNT_LO = 3'd4,
    A_CNT_HI = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic irq_en;
    logic edge_rise;
    logic filt_en;
    logic src_sel;
  } ctrl_t;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  // Each further stage re-registers the one before it.
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cap_filter.sv
module cap_filter #(
  parameter int FLT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic raw,
  output logic lvl
);

  logic [FLT_LEN-1:0] hist_q;
  logic               filt_q;
  logic               filt_now;
  logic               all_hi;
  logic               all_lo;

  // The last FLT_LEN samples of the raw level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= {hist_q[FLT_LEN-2:0], raw};
  end

  assign all_hi = &hist_q;
  assign all_lo = ~|hist_q;

  // A new level is accepted only when every stored sample agrees on it.
  always_comb begin
    if (all_hi)      filt_now = 1'b1;
    else if (all_lo) filt_now = 1'b0;
    else             filt_now = filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) filt_q <= 1'b0;
    else        filt_q <= filt_now;
  end

  assign lvl = en ? filt_now : raw;

  // R3: the held level only moves after a full run of agreeing samples.
  assert_filter_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> ($past(all_hi) || $past(all_lo)));

endmodule

// File: rtl/cap_edge.sv
module cap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise,
  output logic evt
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign evt = rise ? (lvl & ~prev_q) : (~lvl & prev_q);

  // R4: with a fixed polarity, two qualifying edges need at least one cycle between them.
  assert_no_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (!evt || !$stable(rise)));

endmodule

// File: rtl/cap_regs.sv
module cap_regs
  import cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             cap_evt,
  input  logic             glb_irq_en,
  output ctrl_t            ctrl,
  output logic             irq
);

  ctrl_t            ctrl_q;
  logic             flag_q;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BUS_W-1:0] hold_q;

  logic wr_ctrl, wr_stat, wr_cap_lo, wr_cap_hi, wr_cnt_lo, wr_cnt_hi;
  logic rd_cap_lo, rd_cnt_lo;
  logic unused_wdata;

  // Bus decode.
  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat   = bus_wr && (bus_addr == A_STAT);
  assign wr_cap_lo = bus_wr && (bus_addr == A_CAP_LO);
  assign wr_cap_hi = bus_wr && (bus_addr == A_CAP_HI);
  assign wr_cnt_lo = bus_wr && (bus_addr == A_CNT_LO);
  assign wr_cnt_hi = bus_wr && (bus_addr == A_CNT_HI);
  assign rd_cap_lo = bus_rd && (bus_addr == A_CAP_LO);
  assign rd_cnt_lo = bus_rd && (bus_addr == A_CNT_LO);
  assign unused_wdata = ^bus_wdata[BUS_W-1:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[3:0]);
  end

  // Capture flag: a capture wins over a write-one clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag_q <= 1'b0;
    else if (cap_evt)                 flag_q <= 1'b1;
    else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
  end

  // Shared high-byte holding register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hold_q <= '0;
    else if (wr_cap_hi || wr_cnt_hi)  hold_q <= bus_wdata;
    else if (rd_cap_lo)               hold_q <= cap_q[CNT_W-1:BUS_W];
    else if (rd_cnt_lo)               hold_q <= cnt_q[CNT_W-1:BUS_W];
  end

  // Capture register: a hardware capture wins over a bus commit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cap_q <= '0;
    else if (cap_evt)   cap_q <= cnt_q;
    else if (wr_cap_lo) cap_q <= {hold_q, bus_wdata};
  end

  // Free-running counter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (wr_cnt_lo) cnt_q <= {hold_q, bus_wdata};
    else                cnt_q <= cnt_q + CNT_W'(1);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = {4'b0, ctrl_q};
      A_STAT:   bus_rdata = {{(BUS_W-1){1'b0}}, flag_q};
      A_CAP_LO: bus_rdata = cap_q[BUS_W-1:0];
      A_CNT_LO: bus_rdata = cnt_q[BUS_W-1:0];
      A_CAP_HI,
      A_CNT_HI: bus_rdata = hold_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign irq  = flag_q && ctrl_q.irq_en && glb_irq_en;

  // R9: the counter steps by one unless the low byte is committed.
  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt_lo |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R8: the capture register only moves on a capture or a low-byte commit.
  assert_cap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !wr_cap_lo) |=> $stable(cap_q));

  // R5: the flag is only raised by a capture event.
  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cap_evt));

  // R5: a capture always leaves the flag set.
  assert_flag_after_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> flag_q);

endmodule

// File: rtl/capture_unit.sv
module capture_unit
  import cap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FLT_LEN     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cap_pin,
  input  logic       cmp_in,
  input  logic       glb_irq_en,
  output logic       irq
);

  localparam int SRC_N = 2;

  logic [SRC_N-1:0] src_sync;
  logic             src_lvl;
  logic             clean_lvl;
  logic             cap_evt;
  ctrl_t            ctrl;

  cap_sync #(.WIDTH(SRC_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cmp_in, cap_pin}),
    .q     (src_sync)
  );

  assign src_lvl = ctrl.src_sel ? src_sync[1] : src_sync[0];

  cap_filter #(.FLT_LEN(FLT_LEN)) i_filter (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctrl.filt_en),
    .raw   (src_lvl),
    .lvl   (clean_lvl)
  );

  cap_edge i_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (clean_lvl),
    .rise  (ctrl.edge_rise),
    .evt   (cap_evt)
  );

  cap_regs i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cap_evt    (cap_evt),
    .glb_irq_en (glb_irq_en),
    .ctrl       (ctrl),
    .irq        (irq)
  );

  // R6: no request while the global enable is low.
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glb_irq_en);

endmodule

// File: tb/test_capture_unit.sv
`timescale 1ns/1ps
module test_capture_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_pin = 1'b0;
  logic       cmp_in = 1'b0;
  logic       glb_irq_en = 1'b0;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  capture_unit i_capture_unit (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .cmp_in(cmp_in), .glb_irq_en(glb_irq_en), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every bus operation starts and ends on a falling edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  typedef struct packed {
    logic        src;
    logic        filt;
    logic        rise;
    logic        other;
    logic [3:0]  pulse;
    logic        hit;
    logic [3:0]  ofs;
    logic [15:0] base;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd2, 16'h0123},  // R2 pin rising
    '{1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b1, 4'd6, 16'h2345},  // R3 filtered
    '{1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd2, 16'h4567},  // R1 comparator
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 4'd6, 16'h6789},  // R4 falling filtered
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 4'd2, 16'h89AB},  // R4 falling
    '{1'b0, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 4'd0, 16'hABCD},  // R1 other line ignored
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'd3, 1'b0, 4'd0, 16'hCDEF},  // R3 glitch rejected
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd1, 1'b1, 4'd2, 16'hFFF0},  // R2 one-cycle pulse
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'd4, 1'b1, 4'd6, 16'h0FF8}   // R3 four-cycle pulse accepted
  };

  logic [7:0] lo, hi, st;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R10 reset state
    rd(3'd0, lo); check("R10 ctrl", {8'h0, lo}, 16'h0000);
    rd(3'd1, lo); check("R10 flag", {8'h0, lo}, 16'h0000);
    rd(3'd2, lo); rd(3'd3, hi); check("R10 capture", {hi, lo}, 16'h0000);
    check("R10 irq", {15'h0, irq}, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic idle_lvl;
      idle_lvl = ~VEC[i].rise;
      wr(3'd0, {4'b0, 1'b0, VEC[i].rise, VEC[i].filt, VEC[i].src});
      cap_pin = idle_lvl; cmp_in = idle_lvl;
      idle(10);
      wr(3'd1, 8'h01);
      wr(3'd5, VEC[i].base[15:8]);
      wr(3'd4, VEC[i].base[7:0]);
      if (VEC[i].src ^ VEC[i].other) cmp_in = ~idle_lvl;
      else                           cap_pin = ~idle_lvl;
      if (VEC[i].pulse != 0) begin
        idle(int'(VEC[i].pulse));
        cap_pin = idle_lvl; cmp_in = idle_lvl;
      end
      idle(12);
      rd(3'd1, st);
      check($sformatf("R5 flag vec%0d", i), {15'h0, st[0]}, {15'h0, VEC[i].hit});
      if (VEC[i].hit) begin
        rd(3'd2, lo); rd(3'd3, hi);
        check($sformatf("R2/R3 capture value vec%0d", i), {hi, lo},
              VEC[i].base + 16'(VEC[i].ofs));
      end
    end

    // R6 and R5: interrupt gating and write-one clear
    wr(3'd0, 8'h0C);
    cap_pin = 1'b0; cmp_in = 1'b0; glb_irq_en = 1'b0;
    idle(10);
    wr(3'd1, 8'h01);
    cap_pin = 1'b1;
    idle(8);
    check("R6 irq with global off", {15'h0, irq}, 16'h0000);
    glb_irq_en = 1'b1; #1;
    check("R6 irq all enabled", {15'h0, irq}, 16'h0001);
    wr(3'd0, 8'h04); #1;
    check("R6 irq local enable off", {15'h0, irq}, 16'h0000);
    wr(3'd0, 8'h0C);
    wr(3'd1, 8'h00);
    rd(3'd1, st); check("R5 write zero keeps flag", {15'h0, st[0]}, 16'h0001);
    wr(3'd1, 8'h01);
    rd(3'd1, st); check("R5 write one clears flag", {15'h0, st[0]}, 16'h0000);
    check("R6 irq after clear", {15'h0, irq}, 16'h0000);

    // R7 atomic read across a high-byte carry
    wr(3'd5, 8'h12); wr(3'd4, 8'hFE);
    rd(3'd4, lo);
    idle(5);
    rd(3'd5, hi);
    check("R7 atomic counter read", {hi, lo}, 16'h12FE);

    // R9 wrap
    wr(3'd5, 8'hFF); wr(3'd4, 8'hFE);
    rd(3'd4, lo); rd(3'd5, hi);
    check("R9 counter before wrap", {hi, lo}, 16'hFFFE);
    rd(3'd4, lo); rd(3'd5, hi);
    check("R9 counter wrapped", {hi, lo}, 16'h0000);

    // R8 one high byte feeding two commits
    wr(3'd5, 8'hAB);
    wr(3'd2, 8'h11);
    wr(3'd4, 8'h22);
    rd(3'd4, lo); rd(3'd5, hi);
    check("R8 counter commit shared high", {hi, lo}, 16'hAB22);
    rd(3'd2, lo); rd(3'd3, hi);
    check("R8 capture commit shared high", {hi, lo}, 16'hAB11);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule